// File: doc/BRIEF.md
# One-Time-Programmable Configuration Register Bank

This block models a small fuse-backed configuration area behind a plain 32-bit register bus. One part of the map is device information fixed at build time through parameters: a part code, a variant word and a 128-bit unique identifier. The other part is programmable by the customer. It holds a 128-bit link encryption key, two 48-bit network addresses of two words each, a 7-bit oscillator trim, a 4-bit usage indicator and a user data area. Every programmable word comes out of reset as all ones, meaning unprogrammed. A write can only clear bits, as a fuse would.

A protection word is stored four times. When all four copies agree on a defined code, that code sets the access state: unprogrammed, open or restricted. The state decides which groups may be read or written. In the restricted state the key can no longer be read back at all, while the addresses and the trim become read-only.

Accesses are single-cycle requests. The read data and the error flag appear on the cycle after the request. The bus is a control port, so it has no back-pressure: every request is accepted in the cycle it is presented.

Top module: `otp_cfg_bank`

## Requirements
- R1: After reset, `bus_rdata` and `bus_err` are 0, the access state is unprogrammed, and every programmable word reads 0xFFFFFFFF wherever a read is permitted.
- R2: The information words are read-only. The part code sits at byte address 0x0C0, the variant at 0x0C4, and the unique ID words at 0x0D0 + 4n (n=0..3), where word n holds ID bits 32n+31:32n. A write to any of them leaves the word unchanged and raises the error flag.
- R3: A permitted write stores old AND wdata, so bits can only go from 1 to 0. Bits outside the stored field always read 1. The stored fields are bits 15:0 of each address's second word, bits 6:0 of the trim word and bits 3:0 of the usage word.
- R4: The four protection words are at 0x100 + 4n. The state changes only when all four hold the same value, and that value must be 0xFFFFFFFF (unprogrammed), 0x50FA50FA (open) or 0x00000000 (restricted). In every other case the state keeps its last value. A new state governs accesses requested two or more cycles after the write that completed the agreement.
- R5: In the unprogrammed state, reads and writes of the key, address and trim groups are denied.
- R6: In the open state, the key (0x110 + 4n, word n holding key bits 32n+31:32n), the addresses (0x120 + 8n and 0x124 + 8n) and the trim (0x130) allow both read and write.
- R7: In the restricted state, both reads and writes of the key are denied. The address and trim groups may be read but not written.
- R8: A denied read returns 0 and a denied write changes nothing. Both raise `bus_err` for exactly one cycle. Unmapped or unaligned addresses are always denied.
- R9: `bus_rdata` and `bus_err` are registered and answer the request of the previous cycle. `bus_rdata` is 0 when no read was granted. A request with both enables high performs only the write, and its read data is 0.
- R10: The protection words, the usage word (0x154) and the user words (0x198 + 4n, n=0..USER_WORDS-1) can always be read and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; puts every fuse word back to all ones |
| bus_addr | input | ADDR_W | Byte address of the request |
| bus_we | input | 1 | Write request |
| bus_wdata | input | 32 | Write data, ANDed into the word |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Read data for the previous cycle's request |
| bus_err | output | 1 | One-cycle pulse when the previous request was denied |

## Verification
The assertions assume that reset is applied before the first request and that both enables are driven to known values in every cycle after reset. They also assume the address and write data are known whenever an enable is high. The stimulus changes inputs only on falling edges and holds both enables at 0 from time zero. It always leaves an idle cycle after each request, so a change of protection state is always settled before the next access is presented. Full read sweeps over the whole address space run in each of the three states, and these are compared against a word-level model kept in the stimulus.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;

  typedef enum logic [1:0] {
    PS_UNPROG = 2'd0,
    PS_OPEN   = 2'd1,
    PS_RESTR  = 2'd2
  } prot_state_e;

  typedef enum logic [2:0] {
    G_NONE, G_INFO, G_PROT, G_KEY, G_ADDR, G_TRIM, G_USAGE, G_USER
  } grp_e;

  localparam int DW = 32;

  localparam logic [DW-1:0] PROT_BLANK = 32'hFFFF_FFFF;
  localparam logic [DW-1:0] PROT_OPEN  = 32'h50FA_50FA;
  localparam logic [DW-1:0] PROT_RESTR = 32'h0000_0000;

  localparam int N_PROT  = 4;
  localparam int N_KEY   = 4;
  localparam int N_ADDRW = 4;

  // storage indices of the programmable words
  localparam int IDX_PROT  = 0;
  localparam int IDX_KEY   = IDX_PROT + N_PROT;
  localparam int IDX_ADDR  = IDX_KEY + N_KEY;
  localparam int IDX_TRIM  = IDX_ADDR + N_ADDRW;
  localparam int IDX_USAGE = IDX_TRIM + 1;
  localparam int IDX_USER  = IDX_USAGE + 1;

  // word addresses (byte address / 4) of the map
  localparam int WA_PART    = 'h30;
  localparam int WA_VARIANT = 'h31;
  localparam int WA_UID     = 'h34;
  localparam int WA_PROT    = 'h40;
  localparam int WA_KEY     = 'h44;
  localparam int WA_ADDR    = 'h48;
  localparam int WA_TRIM    = 'h4C;
  localparam int WA_USAGE   = 'h55;
  localparam int WA_USER    = 'h66;

  // bits of each word that are real fuses; the rest read as 1
  function automatic logic [DW-1:0] fuse_mask(input int i);
    if (i == IDX_ADDR + 1 || i == IDX_ADDR + 3) return 32'h0000_FFFF;
    if (i == IDX_TRIM)  return 32'h0000_007F;
    if (i == IDX_USAGE) return 32'h0000_000F;
    return '1;
  endfunction

endpackage

// File: rtl/otp_addr_map.sv
module otp_addr_map
  import otp_cfg_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int USER_WORDS = 26,
  localparam int N_WORDS   = IDX_USER + USER_WORDS,
  localparam int IDX_W     = $clog2(N_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic [IDX_W-1:0]  idx,
  output logic [2:0]        info_sel
);

  int wa;

  always_comb begin
    wa       = int'(addr[ADDR_W-1:2]);
    grp      = G_NONE;
    idx      = '0;
    info_sel = '0;
    if (addr[1:0] == 2'b00) begin
      if (wa == WA_PART) begin
        grp = G_INFO; info_sel = 3'd0;
      end else if (wa == WA_VARIANT) begin
        grp = G_INFO; info_sel = 3'd1;
      end else if (wa >= WA_UID && wa < WA_UID + 4) begin
        grp = G_INFO; info_sel = 3'(2 + wa - WA_UID);
      end else if (wa >= WA_PROT && wa < WA_PROT + N_PROT) begin
        grp = G_PROT; idx = IDX_W'(IDX_PROT + wa - WA_PROT);
      end else if (wa >= WA_KEY && wa < WA_KEY + N_KEY) begin
        grp = G_KEY; idx = IDX_W'(IDX_KEY + wa - WA_KEY);
      end else if (wa >= WA_ADDR && wa < WA_ADDR + N_ADDRW) begin
        grp = G_ADDR; idx = IDX_W'(IDX_ADDR + wa - WA_ADDR);
      end else if (wa == WA_TRIM) begin
        grp = G_TRIM; idx = IDX_W'(IDX_TRIM);
      end else if (wa == WA_USAGE) begin
        grp = G_USAGE; idx = IDX_W'(IDX_USAGE);
      end else if (wa >= WA_USER && wa < WA_USER + USER_WORDS) begin
        grp = G_USER; idx = IDX_W'(IDX_USER + wa - WA_USER);
      end
    end
  end

endmodule

// File: rtl/otp_access_policy.sv
module otp_access_policy
  import otp_cfg_pkg::*;
(
  input  grp_e        grp,
  input  prot_state_e pstate,
  output logic        rd_ok,
  output logic        wr_ok
);

  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    unique case (grp)
      G_INFO: rd_ok = 1'b1;
      G_PROT, G_USAGE, G_USER: begin
        rd_ok = 1'b1;
        wr_ok = 1'b1;
      end
      G_KEY: begin
        rd_ok = (pstate == PS_OPEN);
        wr_ok = (pstate == PS_OPEN);
      end
      G_ADDR, G_TRIM: begin
        rd_ok = (pstate == PS_OPEN) || (pstate == PS_RESTR);
        wr_ok = (pstate == PS_OPEN);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/otp_prot_tracker.sv
module otp_prot_tracker
  import otp_cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_PROT-1:0][DW-1:0] prot_words,
  output prot_state_e            pstate
);

  logic agree;

  always_comb begin
    agree = 1'b1;
    for (int i = 1; i < N_PROT; i++)
      if (prot_words[i] != prot_words[0]) agree = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate <= PS_UNPROG;
    end else if (agree) begin
      case (prot_words[0])
        PROT_BLANK: pstate <= PS_UNPROG;
        PROT_OPEN:  pstate <= PS_OPEN;
        PROT_RESTR: pstate <= PS_RESTR;
        default:    pstate <= pstate;
      endcase
    end
  end

  // fuses only clear, so restricted can never be left again
  p_restr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_RESTR) |=> (pstate == PS_RESTR));

  // once open, the words can never return to all ones
  p_open_stays_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_OPEN) |=> (pstate != PS_UNPROG));

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_cfg_pkg::*;
#(
  parameter int N_WORDS = 40,
  localparam int IDX_W  = $clog2(N_WORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           widx,
  input  logic [DW-1:0]              wdata,
  output logic [N_WORDS-1:0][DW-1:0] words
);

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    localparam logic [DW-1:0] MASK = fuse_mask(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '1;
      else if (wr_en && widx == IDX_W'(g))
        words[g] <= words[g] & (wdata | ~MASK);
    end

    p_fuse_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((words[g] & ~$past(words[g])) == '0));
  end

endmodule

// File: rtl/otp_cfg_bank.sv
module otp_cfg_bank
  import otp_cfg_pkg::*;
#(
  parameter int          ADDR_W       = 10,
  parameter int          USER_WORDS   = 26,
  parameter logic [31:0] INFO_PART    = 32'h0000_A5C3,
  parameter logic [31:0] INFO_VARIANT = 32'h0042_3031,
  parameter logic [127:0] INFO_UID    = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              bus_err
);

  localparam int N_WORDS = IDX_USER + USER_WORDS;
  localparam int IDX_W   = $clog2(N_WORDS);

  grp_e                       grp;
  logic [IDX_W-1:0]           idx;
  logic [2:0]                 info_sel;
  prot_state_e                pstate;
  logic                       rd_ok, wr_ok;
  logic [N_WORDS-1:0][DW-1:0] words;
  logic [DW-1:0]              rd_val;
  logic                       wr_fire, rd_fire;

  otp_addr_map #(.ADDR_W(ADDR_W), .USER_WORDS(USER_WORDS)) u_map (
    .addr(bus_addr), .grp(grp), .idx(idx), .info_sel(info_sel)
  );

  otp_access_policy u_policy (
    .grp(grp), .pstate(pstate), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  otp_prot_tracker u_prot (
    .clk(clk), .rst_n(rst_n),
    .prot_words(words[IDX_PROT +: N_PROT]), .pstate(pstate)
  );

  assign wr_fire = bus_we & wr_ok;
  assign rd_fire = bus_re & ~bus_we & rd_ok;

  otp_fuse_array #(.N_WORDS(N_WORDS)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .widx(idx),
    .wdata(bus_wdata), .words(words)
  );

  always_comb begin
    if (grp == G_INFO) begin
      case (info_sel)
        3'd0:    rd_val = INFO_PART;
        3'd1:    rd_val = INFO_VARIANT;
        default: rd_val = INFO_UID[32*(int'(info_sel)-2) +: 32];
      endcase
    end else begin
      rd_val = words[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd_fire ? rd_val : '0;
      bus_err   <= (bus_we & ~wr_ok) | (bus_re & ~bus_we & ~rd_ok);
    end
  end

  p_err_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_we || bus_re));

  p_rdata_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata != '0) |-> $past(bus_re && !bus_we));

  p_denied_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re && !bus_we && !rd_ok) |-> (bus_rdata == '0 && bus_err));

  p_key_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re && grp == G_KEY && pstate != PS_OPEN) |-> (bus_rdata == '0));

  p_info_readonly_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && grp == G_INFO) |-> bus_err);

endmodule

// File: tb/test_otp_cfg_bank.sv
`timescale 1ns/1ps
module test_otp_cfg_bank;

  localparam int           AW    = 10;
  localparam int           USERW = 26;
  localparam int           NW    = 14 + USERW;
  localparam logic [31:0]  PART  = 32'h0000_A5C3;
  localparam logic [31:0]  VARI  = 32'h0042_3031;
  localparam logic [127:0] UID   = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m [0:NW-1];
  int mstate = 0; // 0 unprogrammed, 1 open, 2 restricted

  always #2.5 clk = ~clk;

  otp_cfg_bank #(.ADDR_W(AW), .USER_WORDS(USERW), .INFO_PART(PART),
                 .INFO_VARIANT(VARI), .INFO_UID(UID)) i_otp_cfg_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_err(bus_err)
  );

  // group codes: 0 none,1 info,2 prot,3 key,4 addr,5 trim,6 usage,7 user
  function automatic int m_grp(input int a, output int idx);
    int w;
    idx = 0;
    if (a % 4 != 0) return 0;
    w = a / 4;
    if (w == 'h30) begin idx = 0; return 1; end
    if (w == 'h31) begin idx = 1; return 1; end
    if (w >= 'h34 && w <= 'h37) begin idx = 2 + w - 'h34; return 1; end
    if (w >= 'h40 && w <= 'h43) begin idx = w - 'h40; return 2; end
    if (w >= 'h44 && w <= 'h47) begin idx = 4 + w - 'h44; return 3; end
    if (w >= 'h48 && w <= 'h4B) begin idx = 8 + w - 'h48; return 4; end
    if (w == 'h4C) begin idx = 12; return 5; end
    if (w == 'h55) begin idx = 13; return 6; end
    if (w >= 'h66 && w < 'h66 + USERW) begin idx = 14 + w - 'h66; return 7; end
    return 0;
  endfunction

  function automatic logic [31:0] m_mask(input int i);
    if (i == 9 || i == 11) return 32'h0000_FFFF;
    if (i == 12) return 32'h0000_007F;
    if (i == 13) return 32'h0000_000F;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic bit m_rd_ok(input int g);
    if (g == 1 || g == 2 || g == 6 || g == 7) return 1;
    if (g == 3) return mstate == 1;
    if (g == 4 || g == 5) return mstate != 0;
    return 0;
  endfunction

  function automatic bit m_wr_ok(input int g);
    if (g == 2 || g == 6 || g == 7) return 1;
    if (g >= 3 && g <= 5) return mstate == 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_info(input int i);
    if (i == 0) return PART;
    if (i == 1) return VARI;
    return UID[32*(i-2) +: 32];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_prot_update();
    if (m[0] == m[1] && m[1] == m[2] && m[2] == m[3]) begin
      if (m[0] == 32'hFFFF_FFFF) mstate = 0;
      else if (m[0] == 32'h50FA_50FA) mstate = 1;
      else if (m[0] == 32'h0) mstate = 2;
    end
  endtask

  task automatic do_wr(input int a, input logic [31:0] d, input string req);
    int idx, g;
    bit ok;
    g  = m_grp(a, idx);
    ok = m_wr_ok(g);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    chk({req, " write err"}, {31'b0, bus_err}, {31'b0, !ok});
    chk({req, " write rdata"}, bus_rdata, 32'h0);
    if (ok) begin
      m[idx] = m[idx] & (d | ~m_mask(idx));
      if (g == 2) m_prot_update();
    end
  endtask

  task automatic do_rd(input int a, input string req);
    int idx, g;
    bit ok;
    logic [31:0] exp;
    g   = m_grp(a, idx);
    ok  = m_rd_ok(g);
    exp = !ok ? 32'h0 : (g == 1 ? m_info(idx) : m[idx]);
    @(negedge clk);
    bus_addr = AW'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    chk({req, " read data"}, bus_rdata, exp);
    chk({req, " read err"}, {31'b0, bus_err}, {31'b0, !ok});
  endtask

  task automatic sweep_rd(input string req);
    for (int a = 0; a < (1 << AW); a += 4) do_rd(a, req);
  endtask

  task automatic sweep_wr(input string req);
    for (int a = 'h110; a < 'h198 + 4*USERW; a += 4)
      if (a != 'h134) do_wr(a, 32'hFFFF_FFFF ^ (32'h3 << (a % 29)), req);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) m[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdata", bus_rdata, 32'h0);
    chk("R1 reset err", {31'b0, bus_err}, 32'h0);

    // unprogrammed state
    sweep_rd("R1 R5 R8 unprog sweep");
    do_rd('h101, "R8 unaligned");
    do_rd('h3FC, "R8 unmapped");
    do_wr('h0C0, 32'h0, "R2 part");
    do_wr('h0DC, 32'h0, "R2 uid3");
    do_rd('h0C0, "R2 part after write");
    do_rd('h0DC, "R2 uid3 after write");
    do_wr('h3F0, 32'h0, "R8 unmapped");
    sweep_wr("R5 R10 unprog writes");
    sweep_rd("R5 R10 unprog sweep after writes");
    do_wr('h154, 32'hFFFF_FFF5, "R3 usage");
    do_wr('h154, 32'hFFFF_FFF0, "R3 usage");
    do_rd('h154, "R3 usage upper bits");

    // partial agreement keeps state
    do_wr('h100, 32'h50FA_50FA, "R4");
    do_wr('h104, 32'h50FA_50FA, "R4");
    do_wr('h108, 32'h50FA_50FA, "R4");
    do_rd('h110, "R4 three of four");
    do_wr('h10C, 32'h50FA_50FA, "R4");
    do_rd('h110, "R4 R6 open key");

    // open state
    for (int n = 0; n < 4; n++) do_wr('h110 + 4*n, 32'h1111_1111 * (n + 1), "R6 key");
    do_wr('h120, 32'hA1B2_C3D4, "R6 addr0 hi");
    do_wr('h124, 32'h1234_E5F6, "R3 R6 addr0 lo");
    do_wr('h128, 32'h0F0F_0F0F, "R6 addr1 hi");
    do_wr('h12C, 32'h0000_9876, "R3 R6 addr1 lo");
    do_wr('h130, 32'h0000_0055, "R3 R6 trim");
    do_wr('h130, 32'hFFFF_FFF0, "R3 trim clear only");
    sweep_wr("R3 R6 open writes");
    sweep_rd("R6 open sweep");

    // simultaneous read and write
    @(negedge clk);
    bus_addr = AW'('h198); bus_wdata = 32'h00FF_00FF; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk("R9 both enables rdata", bus_rdata, 32'h0);
    chk("R9 both enables err", {31'b0, bus_err}, 32'h0);
    m[14] = m[14] & 32'h00FF_00FF;
    do_rd('h198, "R9 write happened");

    // move to restricted
    do_wr('h100, 32'h0, "R4");
    do_wr('h104, 32'h0, "R4");
    do_wr('h108, 32'h0, "R4");
    do_rd('h114, "R4 still open");
    do_wr('h10C, 32'h0, "R4");
    do_rd('h114, "R7 key hidden");
    do_wr('h114, 32'h0, "R7 key write");
    do_wr('h120, 32'h0, "R7 addr write");
    do_wr('h130, 32'h0, "R7 trim write");
    sweep_wr("R7 R10 restricted writes");
    sweep_rd("R7 restricted sweep");
    for (int n = 0; n < 4; n++) do_wr('h100 + 4*n, 32'h50FA_50FA, "R3 R4 no reopen");
    do_rd('h110, "R4 stays restricted");
    do_rd('h100, "R10 prot readable");

    done = 1'b1;
    summary();
  end

endmodule